// File: doc/BRIEF.md
# Serial Channel Control Register Interface

This block holds the processor-facing register logic for one channel of a serial controller. The processor drives one 8-bit bus with a write strobe and a select line. The select line picks either the control path or the transmit data path. Control writes reach the channel's write registers indirectly. A write to register 0 loads a 3-bit register pointer. The next control write goes to the register that the pointer names, and the pointer then falls back to zero. Register 0 also carries a command field. Its commands clear single interrupt sources, reset the whole channel, or arm an interrupt for the next received character.

The block keeps four interrupt-pending bits: receive, transmit, external status and error. It also keeps two status bytes. The first shows receive-character-available and transmit-buffer-empty. The second collects error flags. The block holds the transmit byte for the serializer. Register 5 drives the DTR, RTS and break levels, and each level has a one-cycle change strobe. The serializer reports back in two ways: a strobe when it takes the holding byte, and strobes for received characters, status events and errors.

Top module: `serial_chan_regif`

## Requirements
- R1: After reset the pointer is 0, `stat0` is 8'h04 (only bit 2, transmit-buffer-empty, set), `stat1` is 0, `irq_pend` is 0, the receive arm flag is 0, the holding byte is invalid, and DTR, RTS, break and all change strobes are 0.
- R2: A control write while the pointer is 0 loads the pointer from `wdata[2:0]`. A control write while the pointer is non-zero goes to the named register and returns the pointer to 0 on the same edge.
- R3: A register 0 write decodes the command in `wdata[5:3]`. Code 2 clears the status pending bit (`irq_pend[2]`), code 5 clears the transmit pending bit (`irq_pend[1]`), and code 6 clears the error pending bit (`irq_pend[3]`). Codes 0, 1 and 7 change nothing. A clear wins over a set of the same bit in the same cycle.
- R4: Command code 3 is a channel reset. It sets `stat0` to 8'h04, clears `stat1`, clears all four pending bits and the receive arm flag, and invalidates the holding byte. Register 5 and the holding byte value are kept.
- R5: Command code 4 arms the receive interrupt. The next `rx_char` strobe sets `irq_pend[0]` and disarms. An `rx_char` while disarmed sets no pending bit. Every `rx_char` sets `stat0[0]`.
- R6: A data write while register 5 bit 3 (transmit enable) is 0 is ignored. The holding byte, its valid flag, `stat0` bit 2 and `irq_pend[1]` are unchanged.
- R7: A data write while transmit is enabled latches `wdata` into the holding byte, marks it valid, clears `stat0[2]` and clears `irq_pend[1]`, all on one edge.
- R8: A `tx_taken` strobe sets `stat0[2]` and `irq_pend[1]` and invalidates the holding byte. If an accepted data write arrives in the same cycle, the write takes effect and the strobe does not.
- R9: Register 5 drives DTR from bit 7, break from bit 4 and RTS from bit 1. On a register 5 write, each of these bits that differs from its old value pulses its change strobe high for exactly the following cycle. No strobe pulses otherwise.
- R10: `stat_evt` sets `irq_pend[2]`. `err_evt` sets `irq_pend[3]` and ORs `err_code` into `stat1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| ctl_sel | input | 1 | 1 = control write, 0 = transmit data write |
| wdata | input | 8 | Write data bus |
| tx_taken | input | 1 | Serializer took the holding byte |
| rx_char | input | 1 | Serializer received a character |
| stat_evt | input | 1 | External status change event |
| err_evt | input | 1 | Receive error event |
| err_code | input | 8 | Error flags ORed into stat1 on err_evt |
| reg_ptr | output | 3 | Current register pointer |
| stat0 | output | 8 | Status byte 0: bit 0 rx available, bit 2 tx buffer empty |
| stat1 | output | 8 | Status byte 1: sticky error flags |
| irq_pend | output | 4 | Pending bits: 0 rx, 1 tx, 2 status, 3 error |
| rx_armed | output | 1 | Interrupt armed for next received character |
| tx_hold | output | 8 | Transmit holding byte |
| tx_hold_vld | output | 1 | Holding byte valid |
| dtr | output | 1 | DTR level |
| rts | output | 1 | RTS level |
| brk | output | 1 | Break level |
| dtr_chg | output | 1 | One-cycle DTR change strobe |
| rts_chg | output | 1 | One-cycle RTS change strobe |
| brk_chg | output | 1 | One-cycle break change strobe |

## Verification
The bench follows a register 5 write with a second control write. A design that failed to clear the pointer would send that second write into register 5 and move DTR, where it should have run a null command. The bench rewrites register 5 with the same value to catch strobes that fire on any write rather than on a change. It also sends a data write while transmit is disabled, which a design that skipped the enable check would latch. The bench then drives a clear command and a set event into the same pending bit in one cycle, and a data write together with `tx_taken`. A design with the wrong precedence would leave a pending bit set, or mark the new byte as already taken.

// File: rtl/serial_chan_regif.sv
module serial_chan_regif (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       ctl_sel,
  input  logic [7:0] wdata,
  input  logic       tx_taken,
  input  logic       rx_char,
  input  logic       stat_evt,
  input  logic       err_evt,
  input  logic [7:0] err_code,
  output logic [2:0] reg_ptr,
  output logic [7:0] stat0,
  output logic [7:0] stat1,
  output logic [3:0] irq_pend,
  output logic       rx_armed,
  output logic [7:0] tx_hold,
  output logic       tx_hold_vld,
  output logic       dtr,
  output logic       rts,
  output logic       brk,
  output logic       dtr_chg,
  output logic       rts_chg,
  output logic       brk_chg
);
  localparam int TXEN_BIT = 3;
  localparam int DTR_BIT  = 7;
  localparam int BRK_BIT  = 4;
  localparam int RTS_BIT  = 1;
  localparam logic [2:0] CMD_RST_STAT = 3'd2;
  localparam logic [2:0] CMD_CHAN_RST = 3'd3;
  localparam logic [2:0] CMD_ARM_RX   = 3'd4;
  localparam logic [2:0] CMD_RST_TX   = 3'd5;
  localparam logic [2:0] CMD_RST_ERR  = 3'd6;

  logic [7:0] wr5;
  logic       rx_avail, tx_empty;
  logic [3:0] pend_set, pend_clr;

  wire       ctl_wr   = wr_en & ctl_sel;
  wire       dat_wr   = wr_en & ~ctl_sel;
  wire       wr0      = ctl_wr & (reg_ptr == 3'd0);
  wire       wr5_hit  = ctl_wr & (reg_ptr == 3'd5);
  wire [2:0] cmd      = wdata[5:3];
  wire       chan_rst = wr0 & (cmd == CMD_CHAN_RST);
  wire       arm_cmd  = wr0 & (cmd == CMD_ARM_RX);
  wire       tx_acc   = dat_wr & wr5[TXEN_BIT];

  assign stat0 = {5'b0, tx_empty, 1'b0, rx_avail};
  assign dtr   = wr5[DTR_BIT];
  assign rts   = wr5[RTS_BIT];
  assign brk   = wr5[BRK_BIT];

  always_comb begin
    pend_set = {err_evt, stat_evt, tx_taken, rx_char & rx_armed};
    pend_clr = {wr0 & (cmd == CMD_RST_ERR),
                wr0 & (cmd == CMD_RST_STAT),
                tx_acc | (wr0 & (cmd == CMD_RST_TX)),
                1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_ptr     <= 3'd0;
      wr5         <= 8'h00;
      rx_avail    <= 1'b0;
      tx_empty    <= 1'b1;
      stat1       <= 8'h00;
      irq_pend    <= 4'h0;
      rx_armed    <= 1'b0;
      tx_hold     <= 8'h00;
      tx_hold_vld <= 1'b0;
      dtr_chg     <= 1'b0;
      rts_chg     <= 1'b0;
      brk_chg     <= 1'b0;
    end else begin
      dtr_chg <= wr5_hit & (wdata[DTR_BIT] ^ wr5[DTR_BIT]);
      rts_chg <= wr5_hit & (wdata[RTS_BIT] ^ wr5[RTS_BIT]);
      brk_chg <= wr5_hit & (wdata[BRK_BIT] ^ wr5[BRK_BIT]);
      if (ctl_wr) reg_ptr <= wr0 ? wdata[2:0] : 3'd0;
      if (wr5_hit) wr5 <= wdata;
      if (chan_rst) begin
        rx_avail    <= 1'b0;
        tx_empty    <= 1'b1;
        stat1       <= 8'h00;
        irq_pend    <= 4'h0;
        rx_armed    <= 1'b0;
        tx_hold_vld <= 1'b0;
      end else begin
        irq_pend <= (irq_pend | pend_set) & ~pend_clr;
        if (rx_char) rx_avail <= 1'b1;
        if (err_evt) stat1 <= stat1 | err_code;
        if (arm_cmd) rx_armed <= 1'b1;
        else if (rx_char) rx_armed <= 1'b0;
        if (tx_acc) begin
          tx_empty    <= 1'b0;
          tx_hold     <= wdata;
          tx_hold_vld <= 1'b1;
        end else if (tx_taken) begin
          tx_empty    <= 1'b1;
          tx_hold_vld <= 1'b0;
        end
      end
    end
  end

  a_r2_ptr_returns: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && reg_ptr != 3'd0 |=> reg_ptr == 3'd0);

  a_r4_chan_reset: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> stat0 == 8'h04 && stat1 == 8'h00 && irq_pend == 4'h0 && !tx_hold_vld && !rx_armed);

  a_r6_data_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr && !wr5[TXEN_BIT] |=> $stable(tx_hold));

  a_r7_data_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    tx_acc |=> !stat0[2] && !irq_pend[1] && tx_hold_vld && tx_hold == $past(wdata));

  a_r9_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_wr && reg_ptr == 3'd5) |=> !dtr_chg && !rts_chg && !brk_chg);

  a_r9_dtr_strobe_moves: assert property (@(posedge clk) disable iff (!rst_n)
    dtr_chg |-> dtr != $past(dtr));
endmodule

// File: tb/serial_chan_regif_tb.sv
module serial_chan_regif_tb;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, ctl_sel = 0, tx_taken = 0, rx_char = 0, stat_evt = 0, err_evt = 0;
  logic [7:0] wdata = 0, err_code = 0;
  logic [2:0] reg_ptr;
  logic [7:0] stat0, stat1, tx_hold;
  logic [3:0] irq_pend;
  logic rx_armed, tx_hold_vld, dtr, rts, brk, dtr_chg, rts_chg, brk_chg;

  int checks = 0, failures = 0;
  bit done = 0;
  string cur_req = "R1";

  logic [2:0] m_ptr;
  logic [7:0] m_wr5, m_st1, m_hold;
  logic [3:0] m_pend;
  logic m_rxav, m_txe, m_arm, m_vld;
  logic [2:0] m_chg;

  always #(CLK_NS/2) clk = ~clk;

  serial_chan_regif u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ctl_sel(ctl_sel), .wdata(wdata),
    .tx_taken(tx_taken), .rx_char(rx_char), .stat_evt(stat_evt), .err_evt(err_evt),
    .err_code(err_code), .reg_ptr(reg_ptr), .stat0(stat0), .stat1(stat1),
    .irq_pend(irq_pend), .rx_armed(rx_armed), .tx_hold(tx_hold), .tx_hold_vld(tx_hold_vld),
    .dtr(dtr), .rts(rts), .brk(brk), .dtr_chg(dtr_chg), .rts_chg(rts_chg), .brk_chg(brk_chg)
  );

  task automatic chk(input string field, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, field, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ptr = 0; m_wr5 = 0; m_st1 = 0; m_hold = 0; m_pend = 0;
    m_rxav = 0; m_txe = 1; m_arm = 0; m_vld = 0; m_chg = 0;
  endtask

  // Expected next state, written from the requirement text.
  task automatic model_step();
    logic data_ok, at0, at5;
    logic [2:0] code;
    logic [3:0] nxt;
    at0 = wr_en && ctl_sel && m_ptr == 3'd0;
    at5 = wr_en && ctl_sel && m_ptr == 3'd5;
    code = wdata[5:3];
    data_ok = wr_en && !ctl_sel && m_wr5[3];
    m_chg = at5 ? {wdata[7] ^ m_wr5[7], wdata[1] ^ m_wr5[1], wdata[4] ^ m_wr5[4]} : 3'b000;
    if (at0 && code == 3'd3) begin
      m_rxav = 0; m_txe = 1; m_st1 = 0; m_pend = 0; m_arm = 0; m_vld = 0;
    end else begin
      nxt = m_pend;
      if (rx_char && m_arm) nxt[0] = 1;
      if (tx_taken) nxt[1] = 1;
      if (stat_evt) nxt[2] = 1;
      if (err_evt) nxt[3] = 1;
      if (data_ok || (at0 && code == 3'd5)) nxt[1] = 0;
      if (at0 && code == 3'd2) nxt[2] = 0;
      if (at0 && code == 3'd6) nxt[3] = 0;
      m_pend = nxt;
      if (rx_char) m_rxav = 1;
      if (err_evt) m_st1 = m_st1 | err_code;
      if (at0 && code == 3'd4) m_arm = 1;
      else if (rx_char) m_arm = 0;
      if (data_ok) begin m_hold = wdata; m_vld = 1; m_txe = 0; end
      else if (tx_taken) begin m_vld = 0; m_txe = 1; end
    end
    if (at5) m_wr5 = wdata;
    if (wr_en && ctl_sel) m_ptr = at0 ? wdata[2:0] : 3'd0;
  endtask

  task automatic compare_all();
    chk("reg_ptr", 32'(reg_ptr), 32'(m_ptr));
    chk("stat0", 32'(stat0), 32'({5'b0, m_txe, 1'b0, m_rxav}));
    chk("stat1", 32'(stat1), 32'(m_st1));
    chk("irq_pend", 32'(irq_pend), 32'(m_pend));
    chk("rx_armed", 32'(rx_armed), 32'(m_arm));
    chk("tx_hold_vld", 32'(tx_hold_vld), 32'(m_vld));
    chk("tx_hold", 32'(tx_hold), 32'(m_hold));
    chk("dtr_rts_brk", 32'({dtr, rts, brk}), 32'({m_wr5[7], m_wr5[1], m_wr5[4]}));
    chk("change_strobes", 32'({dtr_chg, rts_chg, brk_chg}), 32'(m_chg));
  endtask

  task automatic step(input logic w, input logic c, input logic [7:0] d,
                      input logic tt, input logic rc, input logic se,
                      input logic ee, input logic [7:0] ec);
    wr_en = w; ctl_sel = c; wdata = d; tx_taken = tt; rx_char = rc;
    stat_evt = se; err_evt = ee; err_code = ec;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic cw(input logic [7:0] d); step(1, 1, d, 0, 0, 0, 0, 0); endtask
  task automatic dw(input logic [7:0] d); step(1, 0, d, 0, 0, 0, 0, 0); endtask
  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1"; compare_all();
    chk("R1 stat0 literal", 32'(stat0), 32'h04);

    cur_req = "R2"; cw(8'h05);                  // pointer -> 5
    chk("ptr loaded", 32'(reg_ptr), 32'd5);
    cw(8'h8A);                                  // reg5: dtr, txen, rts
    chk("ptr cleared", 32'(reg_ptr), 32'd0);
    cur_req = "R9";
    chk("strobes dtr+rts", 32'({dtr_chg, rts_chg, brk_chg}), 32'b110);
    cur_req = "R2"; cw(8'h08);                  // must hit reg0 (cmd 1), not reg5
    chk("dtr kept", 32'(dtr), 32'd1);
    cw(8'h03); cw(8'hFF);
    chk("ptr cleared after reg3", 32'(reg_ptr), 32'd0);

    cur_req = "R9"; cw(8'h05); cw(8'h8A);       // same value, no strobe
    chk("no strobe same value", 32'({dtr_chg, rts_chg, brk_chg}), 32'b000);
    cw(8'h05); cw(8'h9A);                       // break toggles
    chk("brk strobe", 32'({dtr_chg, rts_chg, brk_chg}), 32'b001);
    idle();
    chk("strobe one cycle", 32'(brk_chg), 32'd0);

    cur_req = "R7"; dw(8'hA5);
    chk("hold latched", 32'(tx_hold), 32'hA5);
    chk("empty cleared", 32'(stat0[2]), 32'd0);
    cur_req = "R8"; step(0, 0, 0, 1, 0, 0, 0, 0);
    chk("tx pend set", 32'(irq_pend[1]), 32'd1);
    step(1, 0, 8'h3C, 1, 0, 0, 0, 0);           // write wins over taken
    chk("write wins vld", 32'(tx_hold_vld), 32'd1);
    chk("write wins pend", 32'(irq_pend[1]), 32'd0);

    cur_req = "R6"; cw(8'h05); cw(8'h80);       // txen off
    dw(8'h5A);
    chk("ignored hold", 32'(tx_hold), 32'h3C);
    chk("ignored empty", 32'(stat0[2]), 32'd0);

    cur_req = "R3"; step(0, 0, 0, 1, 0, 1, 0, 0);
    cw(8'h00); cw(8'h08); cw(8'h38);            // null codes
    chk("null keeps pend", 32'(irq_pend), 32'b0110);
    cw(8'h10);
    chk("status cleared", 32'(irq_pend[2]), 32'd0);
    step(1, 1, 8'h30, 0, 0, 0, 1, 8'h01);       // clear beats same-cycle set
    chk("err clear wins", 32'(irq_pend[3]), 32'd0);
    cw(8'h28);
    chk("tx cleared", 32'(irq_pend[1]), 32'd0);

    cur_req = "R10"; step(0, 0, 0, 0, 0, 0, 1, 8'h30);
    step(0, 0, 0, 0, 0, 0, 1, 8'h03);
    chk("stat1 or", 32'(stat1), 32'h33);
    chk("err pend", 32'(irq_pend[3]), 32'd1);

    cur_req = "R5"; step(0, 0, 0, 0, 1, 0, 0, 0);
    chk("unarmed no pend", 32'(irq_pend[0]), 32'd0);
    chk("rx avail", 32'(stat0[0]), 32'd1);
    cw(8'h20);
    chk("armed", 32'(rx_armed), 32'd1);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    chk("rx pend", 32'(irq_pend[0]), 32'd1);
    chk("disarmed", 32'(rx_armed), 32'd0);

    cur_req = "R4"; cw(8'h18);
    chk("reset stat0", 32'(stat0), 32'h04);
    chk("reset pend", 32'(irq_pend), 32'h0);
    chk("reset vld", 32'(tx_hold_vld), 32'd0);
    chk("reset keeps dtr", 32'(dtr), 32'd1);

    cur_req = "R3 R5 R7 R8 R9 R10 random";
    for (int i = 0; i < 4000; i++) begin
      logic w, c;
      logic [7:0] d;
      w = ($urandom % 2) == 0;
      c = ($urandom % 3) != 0;
      d = 8'($urandom);
      if (($urandom % 4) == 0) d[2:0] = 3'd5;
      step(w, c, d, ($urandom % 6) == 0, ($urandom % 6) == 0,
           ($urandom % 8) == 0, ($urandom % 8) == 0, 8'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule